// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is an I2C target that gives a bus host access to a register space indexed by a one-byte command. It answers only to its fixed 7-bit address, 1010101 binary, so the host sends 0xAA to write and 0xAB to read. After a write address, the first byte is a command that loads an internal pointer. Any further bytes are stored at the pointer, which then steps on to the next location. A read, whether after a repeated start or as a bare transaction, streams bytes out starting at the pointer.

The pointer keeps its value between transactions. A read with no command phase therefore continues from where the previous access stopped. Commands above a fixed ceiling are refused, and so are writes to locations that the register file marks read-only. The bus lines are sampled with a fast system clock. The block drives SDA only as an open-drain pull-down, and it never holds SCL.

The register file sits outside the block. The block presents a pointer address, write data and a one-cycle write strobe to it. It takes back combinational read data and a read-only flag for the addressed location.

Top module: `i2c_ptr_target`

## Requirements
- R1: An address byte of 0xAA or 0xAB gets an ACK. Any other address byte gets no ACK, and the target leaves SDA released until the next start condition.
- R2: A command byte at or below 0x6B gets an ACK and loads the pointer, so the next write or read uses that location.
- R3: A command byte above 0x6B gets a NACK. The target then ignores the rest of the transaction: it gives no write strobe and does not drive SDA.
- R4: In an incremental write, successive data bytes are written to consecutive locations, and each byte gets an ACK.
- R5: A data byte aimed at a read-only location (below 0x08 in the bench register file) gets a NACK. It produces no write strobe, and the pointer stays unchanged.
- R6: Write address, command, repeated start, then read address returns bytes from the commanded location and from the locations after it, one per byte.
- R7: The pointer persists across transactions. A quick read (0xAB with no command phase) starts at the current pointer.
- R8: The pointer advances only on ACKed bytes. A master NACK ends output and releases SDA. Reading 0x10 and 0x11 with the second byte NACKed leaves the pointer at 0x11.
- R9: A start condition in the middle of a byte discards the partial byte and restarts address reception.
- R10: The write strobe lasts one clock, and SDA is driven or released only while SCL is low.
- R11: After reset, SDA is released and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level (wired-AND bus) |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | PTR_W | Register address (current pointer) |
| reg_wdata | output | 8 | Write data to register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data at reg_addr, combinational |
| reg_ro | input | 1 | Location at reg_addr is read-only |

## Verification
The assertions assume a host that follows the protocol. The host changes SDA only while SCL is low, except for start and stop, and it never sends start or stop while the target is pulling SDA low. Each SCL phase is held for many system clocks, so the synchronizer delay stays hidden. The bench master holds every SCL quarter-phase for six system clocks and moves SDA only in the low phase. Random transactions mix commands on both sides of the ceiling with writes that land in the read-only range.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_CMD, ST_WR, ST_RD, ST_MACK, ST_SACK, ST_SKIP
   } tgt_state_e;
   localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_sh, sda_sh;
   logic scl_d, sda_d;

   for (genvar i = 0; i < STAGES; i++) begin : g_chain
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_sh[0] <= 1'b1;
               sda_sh[0] <= 1'b1;
            end else begin
               scl_sh[0] <= scl_in;
               sda_sh[0] <= sda_in;
            end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_sh[i] <= 1'b1;
               sda_sh[i] <= 1'b1;
            end else begin
               scl_sh[i] <= scl_sh[i-1];
               sda_sh[i] <= sda_sh[i-1];
            end
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_lvl;
         sda_d <= sda_lvl;
      end

   assign scl_lvl   = scl_sh[STAGES-1];
   assign sda_lvl   = sda_sh[STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_d;
   assign scl_fall  = ~scl_lvl & scl_d;
   assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2c_ptr_core.sv
module i2c_ptr_core
   import i2c_ptr_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h55,
   parameter logic [7:0] CMD_MAX  = 8'h6B,
   parameter int         PTR_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_lvl,
   input  logic             sda_lvl,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [7:0]       reg_rdata,
   input  logic             reg_ro,
   output logic             sda_oe,
   output logic [PTR_W-1:0] reg_addr,
   output logic [7:0]       reg_wdata,
   output logic             reg_we
);
   localparam int CNT_W = $clog2(BYTE_W + 1);

   tgt_state_e       state, nxt;
   logic [CNT_W-1:0] bitn;
   logic [7:0]       shreg, txb;
   logic [PTR_W-1:0] ptr;
   logic             inc_pend, mack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         nxt      <= ST_IDLE;
         bitn     <= '0;
         shreg    <= '0;
         txb      <= '0;
         ptr      <= '0;
         inc_pend <= 1'b0;
         mack     <= 1'b0;
         sda_oe   <= 1'b0;
         reg_we   <= 1'b0;
      end else begin
         reg_we <= 1'b0;
         if (start_det) begin
            state  <= ST_ADDR;
            bitn   <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_CMD, ST_WR: begin
                  if (scl_rise && bitn < CNT_W'(BYTE_W)) begin
                     shreg <= {shreg[6:0], sda_lvl};
                     bitn  <= bitn + 1'b1;
                  end else if (scl_fall && bitn == CNT_W'(BYTE_W)) begin
                     bitn <= '0;
                     if (state == ST_ADDR) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           sda_oe   <= 1'b1;
                           state    <= ST_SACK;
                           nxt      <= shreg[0] ? ST_RD : ST_CMD;
                           inc_pend <= 1'b0;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else if (state == ST_CMD) begin
                        if (shreg > CMD_MAX) begin
                           state <= ST_SKIP;
                        end else begin
                           ptr      <= PTR_W'(shreg);
                           sda_oe   <= 1'b1;
                           state    <= ST_SACK;
                           nxt      <= ST_WR;
                           inc_pend <= 1'b0;
                        end
                     end else begin
                        if (reg_ro) begin
                           state <= ST_SKIP;
                        end else begin
                           reg_we   <= 1'b1;
                           sda_oe   <= 1'b1;
                           state    <= ST_SACK;
                           nxt      <= ST_WR;
                           inc_pend <= 1'b1;
                        end
                     end
                  end
               end
               ST_SACK: if (scl_fall) begin
                  bitn  <= '0;
                  state <= nxt;
                  if (inc_pend) ptr <= ptr + 1'b1;
                  if (nxt == ST_RD) begin
                     txb    <= reg_rdata;
                     sda_oe <= ~reg_rdata[7];
                  end else begin
                     sda_oe <= 1'b0;
                  end
               end
               ST_RD: if (scl_fall) begin
                  if (bitn == CNT_W'(BYTE_W - 1)) begin
                     sda_oe <= 1'b0;
                     state  <= ST_MACK;
                  end else begin
                     txb    <= {txb[6:0], 1'b0};
                     sda_oe <= ~txb[6];
                     bitn   <= bitn + 1'b1;
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_lvl;
                     if (!sda_lvl) ptr <= ptr + 1'b1;
                  end else if (scl_fall) begin
                     bitn <= '0;
                     if (mack) begin
                        state  <= ST_RD;
                        txb    <= reg_rdata;
                        sda_oe <= ~reg_rdata[7];
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign reg_addr  = ptr;
   assign reg_wdata = shreg;

   // R10
   sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_lvl);
   // R10
   we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);
   // R5
   we_not_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> !reg_ro);
   // R1
   quiet_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP || state == ST_IDLE) |-> !sda_oe);
   // R3
   cmd_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SACK && nxt == ST_WR && !inc_pend) |-> (ptr <= PTR_W'(CMD_MAX)));
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target #(
   parameter logic [6:0] DEV_ADDR    = 7'h55,
   parameter logic [7:0] CMD_MAX     = 8'h6B,
   parameter int         PTR_W       = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic             sda_in,
   output logic             sda_oe,
   output logic [PTR_W-1:0] reg_addr,
   output logic [7:0]       reg_wdata,
   output logic             reg_we,
   input  logic [7:0]       reg_rdata,
   input  logic             reg_ro
);
   if (PTR_W < 8) begin : g_bad_ptr
      $error("i2c_ptr_target: PTR_W must hold a full command byte");
   end

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det));

   i2c_ptr_core #(.DEV_ADDR(DEV_ADDR), .CMD_MAX(CMD_MAX), .PTR_W(PTR_W)) u_core (
      .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
      .stop_det(stop_det), .reg_rdata(reg_rdata), .reg_ro(reg_ro),
      .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we));
endmodule

// File: tb/sim_i2c_ptr_target.sv
module sim_i2c_ptr_target;
   localparam int QC = 6;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
   logic sda_oe, reg_we, reg_ro;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   wire sda_line = sda_m & ~sda_oe;

   i2c_ptr_target u0 (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
      .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata), .reg_ro(reg_ro));

   logic [7:0] mem [256];
   logic [7:0] exp_mem [256];
   logic [7:0] exp_ptr = 8'h00;
   int we_cnt = 0, drv_cnt = 0, n_chk = 0, n_fail = 0;
   bit done = 0;

   function automatic bit ro_f(input logic [7:0] a);
      return a < 8'h08;
   endfunction
   function automatic bit cmd_ok_f(input logic [7:0] c);
      return c <= 8'h6B;
   endfunction

   assign reg_rdata = mem[reg_addr];
   assign reg_ro    = ro_f(reg_addr);
   always @(posedge clk) begin
      if (reg_we) begin mem[reg_addr] <= reg_wdata; we_cnt++; end
      if (sda_oe) drv_cnt++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic q();
      repeat (QC) @(negedge clk);
   endtask
   task automatic bus_start();
      sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
   endtask
   task automatic bus_stop();
      sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q();
   endtask
   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; q(); scl_m = 1; q(); q(); scl_m = 0; q();
      end
      sda_m = 1; q(); scl_m = 1; q(); ack = ~sda_line; q(); scl_m = 0; q();
   endtask
   task automatic recv_byte(input bit give_ack, output logic [7:0] b);
      sda_m = 1;
      for (int i = 7; i >= 0; i--) begin
         q(); scl_m = 1; q(); b[i] = sda_line; q(); scl_m = 0;
      end
      q(); sda_m = ~give_ack; q(); scl_m = 1; q(); q(); scl_m = 0; q(); sda_m = 1;
   endtask

   task automatic do_write(input logic [7:0] cmd, input int n);
      bit ack; int w0, d0; logic [7:0] d;
      bus_start();
      send_byte(8'hAA, ack); chk(ack, "R1 write address ack", ack, 1);
      w0 = we_cnt;
      send_byte(cmd, ack);
      chk(ack == cmd_ok_f(cmd), "R2/R3 command ack", ack, cmd_ok_f(cmd));
      if (!ack) begin
         d0 = drv_cnt;
         send_byte(8'h00, ack);
         chk(!ack && drv_cnt == d0 && we_cnt == w0, "R3 ignored after bad command", drv_cnt - d0, 0);
         bus_stop(); return;
      end
      exp_ptr = cmd;
      for (int k = 0; k < n; k++) begin
         d = 8'($urandom);
         w0 = we_cnt;
         send_byte(d, ack);
         if (ro_f(exp_ptr)) begin
            chk(!ack && we_cnt == w0, "R5 read-only nack", ack, 0);
            bus_stop(); return;
         end
         chk(ack && we_cnt == w0 + 1, "R4 data ack", ack, 1);
         exp_mem[exp_ptr] = d;
         exp_ptr = exp_ptr + 8'd1;
      end
      bus_stop();
   endtask

   task automatic do_read(input bit quick, input logic [7:0] cmd, input int n);
      bit ack; logic [7:0] b;
      bus_start();
      if (!quick) begin
         send_byte(8'hAA, ack);
         send_byte(cmd, ack);
         chk(ack == cmd_ok_f(cmd), "R2/R3 read command ack", ack, cmd_ok_f(cmd));
         if (!ack) begin bus_stop(); return; end
         exp_ptr = cmd;
         bus_start();
      end
      send_byte(8'hAB, ack); chk(ack, "R1 read address ack", ack, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k < n - 1, b);
         chk(b == exp_mem[exp_ptr], quick ? "R7 quick read data" : "R6 read data", b, exp_mem[exp_ptr]);
         if (k < n - 1) exp_ptr = exp_ptr + 8'd1;
      end
      chk(!sda_oe, "R8 sda released after master nack", sda_oe, 0);
      bus_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      bit ack; int d0; logic [7:0] b;
      void'($urandom(32'h1234_5678));
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'(i * 37 + 5); exp_mem[i] = 8'(i * 37 + 5);
      end
      repeat (10) @(negedge clk);
      chk(!sda_oe && !reg_we, "R11 reset state", {sda_oe, reg_we}, 0);
      rst_n = 1; q();

      do_write(8'h20, 3);           // R2 R4
      do_read(0, 8'h20, 3);         // R6
      do_read(1, 8'h00, 2);         // R7 continues at 0x22
      do_read(0, 8'h10, 2);         // R8 leaves pointer at 0x11
      chk(exp_ptr == 8'h11, "R8 pointer model", exp_ptr, 8'h11);
      do_read(1, 8'h00, 1);         // R8 quick read returns 0x11 data
      do_write(8'h06, 2);           // R5
      do_read(1, 8'h00, 1);         // R5 pointer still 0x06, data unchanged
      do_write(8'h6B, 1);           // R2 boundary
      do_write(8'h6C, 1);           // R3

      // R1 mismatched address
      bus_start(); d0 = drv_cnt;
      send_byte(8'h54, ack); chk(!ack, "R1 foreign address nack", ack, 0);
      send_byte(8'h20, ack); send_byte(8'hFF, ack);
      chk(drv_cnt == d0, "R1 sda untouched after foreign address", drv_cnt - d0, 0);
      bus_stop();

      // R9 start mid-byte
      bus_start();
      for (int i = 0; i < 3; i++) begin
         sda_m = i[0]; q(); scl_m = 1; q(); q(); scl_m = 0; q();
      end
      do_write(8'h30, 2);           // R9
      do_read(0, 8'h30, 2);         // R9

      for (int t = 0; t < 40; t++) begin
         case ($urandom % 3)
            0: do_write(8'($urandom % 8'h78), 1 + int'($urandom % 3));
            1: do_read(0, 8'($urandom % 8'h78), 1 + int'($urandom % 3));
            default: do_read(1, 8'h00, 1 + int'($urandom % 3));
         endcase
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule